// File: doc/BRIEF.md
# BCD Clock-Calendar Counter

This block keeps time of day and the calendar in eight byte-wide registers and moves them forward by one second on every pulse of a one-second tick input. Seconds, minutes, hours (24-hour), date, month and year are held as packed BCD; the day of week is a plain 1-7 count. A single-cycle read/write port with a 3-bit address and a byte of data gives software access to every register. Reads are combinational from the selected address.

Alongside the counters the block keeps a stop flag that freezes timekeeping, a sticky oscillator-fail flag driven by an external detector pulse, and a century flag that flips on the year wrap when its enable is set. The eighth register holds the oscillator trim setting. It is only stored here and is driven out unchanged to the prescaler that produces the tick. When software writes the seconds register, the block asks that prescaler to restart its sub-second count, so the next tick arrives a full second after the write.

Top module: `rtc_calendar_core`

## Requirements
- R1: After a synchronous reset the registers read: address 0 = 0x00, 1 = 0x80 (fail flag set, minutes 00), 2 = 0x00, 3 = 0x01, 4 = 0x01, 5 = 0x01, 6 = 0x00, 7 = 0x00.
- R2: Register layout: 0 = {stop, seconds[6:0]}, 1 = {fail, minutes[6:0]}, 2 = {century enable, century, hours[5:0]}, 3 = {00000, weekday[2:0]}, 4 = {00, date[5:0]}, 5 = {000, month[4:0]}, 6 = year[7:0], 7 = trim byte. Bits shown as 0 always read 0, whatever was written.
- R3: Each accepted tick advances seconds in BCD. The sequence runs from 00 to 59, then wraps to 00 and carries into minutes. Minutes wrap the same way and carry into hours. Hours wrap from 23 to 00, and that wrap carries into the date.
- R4: While the stop bit (address 0, bit 7) is 1, ticks are ignored and no time or date field changes.
- R5: A pulse on osc_fail sets bit 7 of address 1. The bit stays 1 until software writes a 0 there. A pulse in the same cycle as such a write leaves the bit at 1.
- R6: The date wraps to 01 after the last day of the month. The last day is 30 for months 04, 06, 09 and 11, and 31 for the other months except February. February ends on day 29 when the BCD year is a multiple of 4 (including 00) and on day 28 otherwise. A month wrap from 12 to 01 increments the year.
- R7: At each midnight wrap the weekday increments, and it goes from 7 back to 1.
- R8: When the year wraps from 99 to 00, the century bit (address 2, bit 6) inverts if the enable bit (address 2, bit 7) is 1 and holds its value if the enable is 0.
- R9: Address 7 stores the written byte, reads it back, and drives it on cal_cfg. Ticks do not change it.
- R10: A write to address 0 raises subsec_clr for exactly the one cycle after the write. A tick arriving in the same cycle as any register write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| osc_fail | input | 1 | One-cycle pulse from the oscillator-stop detector |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| cal_cfg | output | 8 | Stored trim byte exported to the prescaler |
| subsec_clr | output | 1 | One-cycle request to restart the sub-second count |

## Verification
The assertions assume that sec_tick and osc_fail are single-cycle pulses synchronous to clk. They also assume that software only writes values inside each field's legal BCD range, because the counters compare for equality with their wrap values and would not recover from an out-of-range digit. The stimulus writes out-of-range bytes only to check the masking of unused bits, and it then rewrites every field with legal values before any tick is issued. Ticks are spaced at least one idle cycle apart, and every tick is driven half a cycle away from the sampling edge.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    typedef enum logic [2:0] {
        A_SEC  = 3'd0,
        A_MIN  = 3'd1,
        A_HOUR = 3'd2,
        A_WDAY = 3'd3,
        A_DATE = 3'd4,
        A_MON  = 3'd5,
        A_YEAR = 3'd6,
        A_TRIM = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic [6:0] sec;
        logic [6:0] min;
        logic [5:0] hr;
        logic [2:0] wday;
        logic [5:0] date;
        logic [4:0] mon;
        logic [7:0] yr;
    } caltime_t;

    localparam caltime_t TIME_RESET = '{
        sec: 7'h00, min: 7'h00, hr: 6'h00, wday: 3'd1,
        date: 6'h01, mon: 5'h01, yr: 8'h00
    };

    // Two-digit BCD increment, no range check.
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        logic [7:0] r;
        if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
        else                r = {v[7:4], v[3:0] + 4'd1};
        return r;
    endfunction

    // Year divisible by four from its BCD digits: 10 mod 4 equals 2.
    function automatic logic bcd_leap(input logic [7:0] y);
        logic [1:0] m;
        m = {y[4], 1'b0} + y[1:0];
        return (m == 2'd0);
    endfunction

    // Last day of the month, BCD.
    function automatic logic [5:0] month_last_day(input logic [4:0] m, input logic [7:0] y);
        logic [5:0] d;
        case (m)
            5'h02:                      d = bcd_leap(y) ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: d = 6'h30;
            default:                    d = 6'h31;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
    import rtc_cal_pkg::*;
(
    input  logic       advance,
    input  logic [6:0] sec,
    input  logic [6:0] min,
    input  logic [5:0] hr,
    output logic [6:0] sec_n,
    output logic [6:0] min_n,
    output logic [5:0] hr_n,
    output logic       day_carry
);
    always_comb begin
        sec_n     = sec;
        min_n     = min;
        hr_n      = hr;
        day_carry = 1'b0;
        if (advance) begin
            if (sec == 7'h59) begin
                sec_n = 7'h00;
                if (min == 7'h59) begin
                    min_n = 7'h00;
                    if (hr == 6'h23) begin
                        hr_n      = 6'h00;
                        day_carry = 1'b1;
                    end else begin
                        hr_n = 6'(bcd_inc({2'b00, hr}));
                    end
                end else begin
                    min_n = 7'(bcd_inc({1'b0, min}));
                end
            end else begin
                sec_n = 7'(bcd_inc({1'b0, sec}));
            end
        end
    end
endmodule

// File: rtl/rtc_date_chain.sv
module rtc_date_chain
    import rtc_cal_pkg::*;
(
    input  logic       day_carry,
    input  logic [2:0] wday,
    input  logic [5:0] date,
    input  logic [4:0] mon,
    input  logic [7:0] yr,
    output logic [2:0] wday_n,
    output logic [5:0] date_n,
    output logic [4:0] mon_n,
    output logic [7:0] yr_n,
    output logic       century_wrap
);
    logic [5:0] last_day;

    assign last_day = month_last_day(mon, yr);

    always_comb begin
        wday_n       = wday;
        date_n       = date;
        mon_n        = mon;
        yr_n         = yr;
        century_wrap = 1'b0;
        if (day_carry) begin
            wday_n = (wday == 3'd7) ? 3'd1 : wday + 3'd1;
            if (date == last_day) begin
                date_n = 6'h01;
                if (mon == 5'h12) begin
                    mon_n = 5'h01;
                    if (yr == 8'h99) begin
                        yr_n         = 8'h00;
                        century_wrap = 1'b1;
                    end else begin
                        yr_n = bcd_inc(yr);
                    end
                end else begin
                    mon_n = 5'(bcd_inc({3'b000, mon}));
                end
            end else begin
                date_n = 6'(bcd_inc({2'b00, date}));
            end
        end
    end
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_cal_pkg::*;
#(
    parameter logic FAIL_AT_RESET = 1'b1,
    parameter logic [7:0] TRIM_RESET = 8'h00
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sec_tick,
    input  logic       osc_fail,
    input  logic       reg_we,
    input  logic [2:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic [7:0] cal_cfg,
    output logic       subsec_clr
);
    caltime_t   tm, tm_adv;
    logic       stop_q, fail_q, cen_en_q, cen_q;
    logic [7:0] trim_q;
    logic       subsec_q;
    logic       advance, day_carry, century_wrap;
    reg_addr_e  wa;

    assign wa      = reg_addr_e'(reg_addr);
    assign advance = sec_tick && !stop_q && !reg_we;

    rtc_time_chain u_time (
        .advance  (advance),
        .sec      (tm.sec),
        .min      (tm.min),
        .hr       (tm.hr),
        .sec_n    (tm_adv.sec),
        .min_n    (tm_adv.min),
        .hr_n     (tm_adv.hr),
        .day_carry(day_carry)
    );

    rtc_date_chain u_date (
        .day_carry   (day_carry),
        .wday        (tm.wday),
        .date        (tm.date),
        .mon         (tm.mon),
        .yr          (tm.yr),
        .wday_n      (tm_adv.wday),
        .date_n      (tm_adv.date),
        .mon_n       (tm_adv.mon),
        .yr_n        (tm_adv.yr),
        .century_wrap(century_wrap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tm       <= TIME_RESET;
            stop_q   <= 1'b0;
            fail_q   <= FAIL_AT_RESET;
            cen_en_q <= 1'b0;
            cen_q    <= 1'b0;
            trim_q   <= TRIM_RESET;
            subsec_q <= 1'b0;
        end else begin
            subsec_q <= reg_we && (wa == A_SEC);
            if (reg_we) begin
                case (wa)
                    A_SEC:  begin stop_q <= reg_wdata[7]; tm.sec <= reg_wdata[6:0]; end
                    A_MIN:  begin fail_q <= reg_wdata[7] | osc_fail; tm.min <= reg_wdata[6:0]; end
                    A_HOUR: begin
                        cen_en_q <= reg_wdata[7];
                        cen_q    <= reg_wdata[6];
                        tm.hr    <= reg_wdata[5:0];
                    end
                    A_WDAY: tm.wday <= reg_wdata[2:0];
                    A_DATE: tm.date <= reg_wdata[5:0];
                    A_MON:  tm.mon  <= reg_wdata[4:0];
                    A_YEAR: tm.yr   <= reg_wdata;
                    default: trim_q <= reg_wdata;
                endcase
                if (osc_fail) fail_q <= 1'b1;
            end else begin
                tm <= tm_adv;
                if (osc_fail) fail_q <= 1'b1;
                if (century_wrap && cen_en_q) cen_q <= ~cen_q;
            end
        end
    end

    always_comb begin
        case (wa)
            A_SEC:   reg_rdata = {stop_q, tm.sec};
            A_MIN:   reg_rdata = {fail_q, tm.min};
            A_HOUR:  reg_rdata = {cen_en_q, cen_q, tm.hr};
            A_WDAY:  reg_rdata = {5'b00000, tm.wday};
            A_DATE:  reg_rdata = {2'b00, tm.date};
            A_MON:   reg_rdata = {3'b000, tm.mon};
            A_YEAR:  reg_rdata = tm.yr;
            default: reg_rdata = trim_q;
        endcase
    end

    assign cal_cfg    = trim_q;
    assign subsec_clr = subsec_q;

    // R4: a stopped clock with no write keeps every time and date field.
    p_stop_freeze_r4: assert property (@(posedge clk) disable iff (rst)
        (stop_q && !reg_we) |=> $stable(tm));

    // R5: the fail detector pulse always leaves the flag set.
    p_fail_set_r5: assert property (@(posedge clk) disable iff (rst)
        osc_fail |=> fail_q);

    // R5: only a write to the minutes address can clear the flag.
    p_fail_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (fail_q && !(reg_we && wa == A_MIN)) |=> fail_q);

    // R7: a carry out of the hour chain leaves the time at midnight.
    p_midnight_r7: assert property (@(posedge clk) disable iff (rst)
        day_carry |=> (tm.sec == 7'h00 && tm.min == 7'h00 && tm.hr == 6'h00));

    // R8: with the enable clear the century bit only changes by a write.
    p_century_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!cen_en_q && !(reg_we && wa == A_HOUR)) |=> $stable(cen_q));

    // R9: the trim byte changes only by a write to its address.
    p_trim_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && wa == A_TRIM) |=> $stable(cal_cfg));

    // R10: a seconds write requests a sub-second restart next cycle, nothing else does.
    p_subsec_req_r10: assert property (@(posedge clk) disable iff (rst)
        (reg_we && wa == A_SEC) |=> subsec_clr);
    p_subsec_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && wa == A_SEC) |=> !subsec_clr);

endmodule

// File: tb/test_rtc_calendar_core.sv
module test_rtc_calendar_core;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sec_tick = 1'b0;
    logic       osc_fail = 1'b0;
    logic       reg_we = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [7:0] cal_cfg;
    logic       subsec_clr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    rtc_calendar_core i_rtc_calendar_core (
        .clk(clk), .rst(rst), .sec_tick(sec_tick), .osc_fail(osc_fail),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cal_cfg(cal_cfg), .subsec_clr(subsec_clr)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [2:0] a, input logic [7:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic tick();
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    // hours byte carries century enable/bit; seconds written last (stop clear)
    task automatic set_all(input logic [7:0] hr_b, input logic [7:0] mn, input logic [7:0] sc,
                           input logic [7:0] wd, input logic [7:0] dt, input logic [7:0] mo,
                           input logic [7:0] yr);
        wr(3'd2, hr_b); wr(3'd1, mn); wr(3'd3, wd);
        wr(3'd4, dt); wr(3'd5, mo); wr(3'd6, yr); wr(3'd0, sc);
    endtask

    task automatic t_reset();
        rd_check("R1 sec", 3'd0, 8'h00);
        rd_check("R1 min/fail", 3'd1, 8'h80);
        rd_check("R1 hour", 3'd2, 8'h00);
        rd_check("R1 wday", 3'd3, 8'h01);
        rd_check("R1 date", 3'd4, 8'h01);
        rd_check("R1 month", 3'd5, 8'h01);
        rd_check("R1 year", 3'd6, 8'h00);
        rd_check("R1 trim", 3'd7, 8'h00);
        check("R1 cal_cfg", cal_cfg, 8'h00);
        check("R1 subsec_clr", {7'd0, subsec_clr}, 8'h00);
    endtask

    task automatic t_layout();
        wr(3'd3, 8'hFF); rd_check("R2 wday mask", 3'd3, 8'h07);
        wr(3'd4, 8'hFF); rd_check("R2 date mask", 3'd4, 8'h3F);
        wr(3'd5, 8'hFF); rd_check("R2 month mask", 3'd5, 8'h1F);
        wr(3'd6, 8'h47); rd_check("R2 year", 3'd6, 8'h47);
        wr(3'd2, 8'h17); rd_check("R2 hour", 3'd2, 8'h17);
    endtask

    task automatic t_time_carry();
        set_all(8'h23, 8'h59, 8'h58, 8'h03, 8'h15, 8'h06, 8'h24);
        tick(); rd_check("R3 sec 58->59", 3'd0, 8'h59);
        rd_check("R3 min held", 3'd1, 8'h59);
        tick();
        rd_check("R3 sec wrap", 3'd0, 8'h00);
        rd_check("R3 min wrap", 3'd1, 8'h00);
        rd_check("R3 hour wrap", 3'd2, 8'h00);
        rd_check("R3 date carry", 3'd4, 8'h16);
        rd_check("R7 wday inc", 3'd3, 8'h04);
        wr(3'd0, 8'h09); tick(); rd_check("R3 BCD digit carry", 3'd0, 8'h10);
        wr(3'd1, 8'h19); wr(3'd0, 8'h59); tick();
        rd_check("R3 min BCD carry", 3'd1, 8'h20);
    endtask

    task automatic t_stop();
        wr(3'd0, 8'h90);
        tick(); tick(); tick();
        rd_check("R4 stopped sec", 3'd0, 8'h90);
        rd_check("R4 stopped min", 3'd1, 8'h20);
        wr(3'd0, 8'h10); tick();
        rd_check("R4 resumed", 3'd0, 8'h11);
    endtask

    task automatic t_fail();
        wr(3'd1, 8'h05); rd_check("R5 cleared", 3'd1, 8'h05);
        @(negedge clk); osc_fail = 1'b1; @(negedge clk); osc_fail = 1'b0;
        rd_check("R5 set by pulse", 3'd1, 8'h85);
        tick(); tick(); rd_check("R5 sticky", 3'd1, 8'h85);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'd1; reg_wdata = 8'h06; osc_fail = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; osc_fail = 1'b0;
        rd_check("R5 pulse beats clear", 3'd1, 8'h86);
        wr(3'd1, 8'h06); rd_check("R5 software clear", 3'd1, 8'h06);
    endtask

    task automatic day_end(input string req, input logic [7:0] dt, input logic [7:0] mo,
                           input logic [7:0] yr, input logic [7:0] exp_dt,
                           input logic [7:0] exp_mo, input logic [7:0] exp_yr);
        set_all(8'h23, 8'h59, 8'h59, 8'h02, dt, mo, yr);
        tick();
        rd_check(req, 3'd4, exp_dt);
        rd_check(req, 3'd5, exp_mo);
        rd_check(req, 3'd6, exp_yr);
    endtask

    task automatic t_months();
        day_end("R6 Apr30", 8'h30, 8'h04, 8'h24, 8'h01, 8'h05, 8'h24);
        day_end("R6 Jan30", 8'h30, 8'h01, 8'h24, 8'h31, 8'h01, 8'h24);
        day_end("R6 Nov30", 8'h30, 8'h11, 8'h21, 8'h01, 8'h12, 8'h21);
        day_end("R6 Feb28 non-leap", 8'h28, 8'h02, 8'h23, 8'h01, 8'h03, 8'h23);
        day_end("R6 Feb28 leap", 8'h28, 8'h02, 8'h24, 8'h29, 8'h02, 8'h24);
        day_end("R6 Feb29 leap", 8'h29, 8'h02, 8'h96, 8'h01, 8'h03, 8'h96);
        day_end("R6 Feb28 year00", 8'h28, 8'h02, 8'h00, 8'h29, 8'h02, 8'h00);
        day_end("R6 Feb28 year10", 8'h28, 8'h02, 8'h10, 8'h01, 8'h03, 8'h10);
        day_end("R6 Dec31", 8'h31, 8'h12, 8'h19, 8'h01, 8'h01, 8'h20);
    endtask

    task automatic t_wday();
        set_all(8'h23, 8'h59, 8'h59, 8'h07, 8'h10, 8'h03, 8'h25);
        tick(); rd_check("R7 wday 7->1", 3'd3, 8'h01);
    endtask

    task automatic t_century();
        set_all(8'h80 | 8'h23, 8'h59, 8'h59, 8'h05, 8'h31, 8'h12, 8'h99);
        tick();
        rd_check("R8 year wrap", 3'd6, 8'h00);
        rd_check("R8 century flips", 3'd2, 8'hC0);
        set_all(8'h40 | 8'h23, 8'h59, 8'h59, 8'h05, 8'h31, 8'h12, 8'h99);
        tick();
        rd_check("R8 century held", 3'd2, 8'h40);
        set_all(8'hC0 | 8'h23, 8'h59, 8'h59, 8'h05, 8'h31, 8'h12, 8'h99);
        tick();
        rd_check("R8 century flips back", 3'd2, 8'h80);
    endtask

    task automatic t_trim();
        wr(3'd7, 8'hA5);
        rd_check("R9 trim readback", 3'd7, 8'hA5);
        check("R9 cal_cfg", cal_cfg, 8'hA5);
        tick(); tick();
        check("R9 cal_cfg after ticks", cal_cfg, 8'hA5);
    endtask

    task automatic t_subsec();
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h30;
        @(negedge clk);
        reg_we = 1'b0;
        check("R10 subsec pulse", {7'd0, subsec_clr}, 8'h01);
        @(negedge clk);
        check("R10 subsec single", {7'd0, subsec_clr}, 8'h00);
        wr(3'd1, 8'h07);
        check("R10 no pulse other addr", {7'd0, subsec_clr}, 8'h00);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'd6; reg_wdata = 8'h33; sec_tick = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; sec_tick = 1'b0;
        rd_check("R10 tick dropped on write", 3'd0, 8'h30);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_layout();
        t_time_carry();
        t_stop();
        t_fail();
        t_months();
        t_wday();
        t_century();
        t_trim();
        t_subsec();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule